// File: doc/BRIEF.md
# Logarithmic 8-bit Integer Codec

This block converts between an unsigned 20-bit integer and a compact 8-bit code. The upper nibble of a code selects one of sixteen segments. The lower nibble selects a step inside that segment. Segment e starts at 16·(2^e − 1), and its steps are 2^e wide. Small values therefore keep full precision, and large values are stored with a relative error that stays roughly constant.

The block has two independent paths, each with its own valid-in and valid-out. The decode path expands a code into its integer value using only shifts and one adder. The encode path takes an integer and works out its segment in three steps:
- It first estimates the exponent from the position of the most significant set bit.
- If the value lies below that estimated segment, it moves down one segment.
- If the value reaches the next segment's start, it moves up one segment.

The step inside the segment is then found by truncation. Both results are registered, so each path has a latency of exactly one clock. A decode and an encode may be issued in the same cycle.

Top module: `log8_codec`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, both valid outputs are low and both data outputs are zero.
- R2: A code with exponent e = code[7:4] and mantissa m = code[3:0] decodes to 16·(2^e − 1) + m·2^e. dec_val_o carries this value, and dec_vld_o is high, in the cycle after dec_vld_i was high.
- R3: An encoded value v gets the exponent E for which 16·(2^E − 1) ≤ v < 16·(2^(E+1) − 1), with E limited to 15. The code is E·16 + ((v − 16·(2^E − 1)) >> E), with the mantissa saturated at 15. enc_code_o carries this code, and enc_vld_o is high, in the cycle after enc_vld_i was high.
- R4: Values at a segment boundary encode into the upper segment even where the bit-position estimate points one segment lower. 240 and 241 both encode as 0x40, 239 as 0x3F, and 112 as 0x30.
- R5: Values below 16 encode to the code equal to the value, and 0 encodes to 0x00.
- R6: Any value of 1015792 or more (the decoded value of 0xFF) encodes to 0xFF.
- R7: For every code from 0x00 to 0xFF, encoding its decoded value returns the same code.
- R8: Decoded values strictly increase with the code, from 0x00 through 0xFF.
- R9: When a path's valid-in is low, its valid-out drops low in the next cycle and its data output keeps its last value. Neither path disturbs the other when both are used in the same cycle.
- R10: Inside a segment the mantissa is truncated: 119 encodes as 0x30, 120 as 0x31, and 255 as 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_vld_i | input | 1 | Decode request valid |
| dec_code_i | input | 8 | Code to expand |
| dec_vld_o | output | 1 | Decode result valid, one cycle after request |
| dec_val_o | output | 20 | Expanded integer value |
| enc_vld_i | input | 1 | Encode request valid |
| enc_val_i | input | 20 | Integer to compress |
| enc_vld_o | output | 1 | Encode result valid, one cycle after request |
| enc_code_o | output | 8 | Compressed code |

## Verification
The decoder is tried with the first and last code of several segments:
- The first code of a segment isolates the segment base.
- The last code of a segment isolates the mantissa shift.

The encoder is tried with values on both sides of segment starts, where the bit-position estimate and the true segment disagree. It is also tried with values inside a step, which separate truncation from rounding, and with values beyond the top code, which exercise saturation.

Every code is then sent through the decoder and its result through the encoder. Any asymmetry between the two paths breaks this round trip, and any misordered segment breaks the strict increase of the decoded values. The hold cases send a request followed by changed data with valid low, to show the registers only load on valid.

// File: rtl/log8_pkg.sv
package log8_pkg;

    // Default field widths of the code
    localparam int LOG8_EXP_W = 4;
    localparam int LOG8_MAN_W = 4;

    // Exponent correction step chosen by the encoder
    typedef enum logic [1:0] {
        ADJ_KEEP = 2'd0,
        ADJ_DOWN = 2'd1,
        ADJ_UP   = 2'd2
    } log8_adj_e;

endpackage

// File: rtl/log8_seg_base.sv
// Start value of segment e: ((2^EMAX - 1) >> (EMAX - e)) << MAN_W
module log8_seg_base #(
    parameter int EXP_W = 4,
    parameter int MAN_W = 4,
    parameter int VAL_W = 20
) (
    input  logic [EXP_W-1:0] exp_i,
    output logic [VAL_W-1:0] base_o
);
    localparam int EMAX = (1 << EXP_W) - 1;
    localparam logic [VAL_W-1:0] ONES = VAL_W'((1 << EMAX) - 1);

    logic [EXP_W-1:0] rsh;

    always_comb begin
        rsh    = EXP_W'(EMAX) - exp_i;
        base_o = (ONES >> rsh) << MAN_W;
    end
endmodule

// File: rtl/log8_msb_find.sv
// Position of the highest set bit, with a flag for a non-zero input
module log8_msb_find #(
    parameter int W  = 20,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [PW-1:0] pos_o,
    output logic          any_o
);
    always_comb begin
        pos_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) pos_o = PW'(i);
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/log8_decoder.sv
module log8_decoder #(
    parameter int EXP_W = 4,
    parameter int MAN_W = 4,
    parameter int VAL_W = 20
) (
    input  logic [EXP_W+MAN_W-1:0] code_i,
    output logic [VAL_W-1:0]       val_o
);
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic [VAL_W-1:0] seg_start;
    logic [VAL_W-1:0] step_ofs;

    assign ex = code_i[EXP_W+MAN_W-1:MAN_W];
    assign mn = code_i[MAN_W-1:0];

    log8_seg_base #(.EXP_W(EXP_W), .MAN_W(MAN_W), .VAL_W(VAL_W)) u_base (
        .exp_i  (ex),
        .base_o (seg_start)
    );

    always_comb begin
        step_ofs = {{(VAL_W-MAN_W){1'b0}}, mn} << ex;
        val_o    = seg_start + step_ofs;
    end
endmodule

// File: rtl/log8_encoder.sv
module log8_encoder
    import log8_pkg::*;
#(
    parameter int EXP_W = 4,
    parameter int MAN_W = 4,
    parameter int VAL_W = 20
) (
    input  logic [VAL_W-1:0]       val_i,
    output logic [EXP_W+MAN_W-1:0] code_o
);
    localparam int EMAX = (1 << EXP_W) - 1;
    localparam int MMAX = (1 << MAN_W) - 1;
    localparam int PW   = $clog2(VAL_W);

    logic [PW-1:0]    msb_pos;
    logic             msb_any;
    logic [EXP_W-1:0] e_est;
    logic [EXP_W-1:0] e_mid;
    logic [EXP_W-1:0] e_mid_inc;
    logic [EXP_W-1:0] e_fin;
    logic [VAL_W-1:0] base_est;
    logic [VAL_W-1:0] base_next;
    logic [VAL_W-1:0] base_fin;
    logic [VAL_W-1:0] diff;
    logic [VAL_W-1:0] shr;
    logic [MAN_W-1:0] mant;
    logic             go_down;
    logic             go_up;
    log8_adj_e        adj;

    log8_msb_find #(.W(VAL_W), .PW(PW)) u_msb (
        .vec_i (val_i),
        .pos_o (msb_pos),
        .any_o (msb_any)
    );

    // First estimate: MSB position minus mantissa width, clamped
    always_comb begin
        if (!msb_any || msb_pos < PW'(MAN_W))
            e_est = '0;
        else if ((msb_pos - PW'(MAN_W)) > PW'(EMAX))
            e_est = EXP_W'(EMAX);
        else
            e_est = EXP_W'(msb_pos - PW'(MAN_W));
    end

    log8_seg_base #(.EXP_W(EXP_W), .MAN_W(MAN_W), .VAL_W(VAL_W)) u_base_est (
        .exp_i  (e_est),
        .base_o (base_est)
    );

    // Step down when the value lies under the estimated segment
    always_comb begin
        go_down   = (val_i < base_est) && (e_est != '0);
        e_mid     = go_down ? e_est - 1'b1 : e_est;
        e_mid_inc = e_mid + 1'b1;
    end

    log8_seg_base #(.EXP_W(EXP_W), .MAN_W(MAN_W), .VAL_W(VAL_W)) u_base_next (
        .exp_i  (e_mid_inc),
        .base_o (base_next)
    );

    // Step up when the value reaches the following segment
    always_comb begin
        go_up = (e_mid != EXP_W'(EMAX)) && (val_i >= base_next);
        if (go_down)    adj = ADJ_DOWN;
        else if (go_up) adj = ADJ_UP;
        else            adj = ADJ_KEEP;
    end

    always_comb begin
        unique case (adj)
            ADJ_KEEP: e_fin = e_mid;
            ADJ_DOWN: e_fin = e_mid;
            ADJ_UP:   e_fin = e_mid_inc;
            default:  e_fin = e_mid;
        endcase
    end

    log8_seg_base #(.EXP_W(EXP_W), .MAN_W(MAN_W), .VAL_W(VAL_W)) u_base_fin (
        .exp_i  (e_fin),
        .base_o (base_fin)
    );

    // R3
    always_comb begin
        seg_floor_chk: assert (val_i >= base_fin)
            else $error("encoder picked a segment above the value");
    end

    always_comb begin
        diff = val_i - base_fin;
        shr  = diff >> e_fin;
        mant = (shr > VAL_W'(MMAX)) ? MAN_W'(MMAX) : shr[MAN_W-1:0];
        code_o = {e_fin, mant};
    end
endmodule

// File: rtl/log8_codec.sv
module log8_codec
    import log8_pkg::*;
#(
    parameter int EXP_W = LOG8_EXP_W,
    parameter int MAN_W = LOG8_MAN_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         dec_vld_i,
    input  logic [EXP_W+MAN_W-1:0]       dec_code_i,
    output logic                         dec_vld_o,
    output logic [(1<<EXP_W)+MAN_W-1:0]  dec_val_o,
    input  logic                         enc_vld_i,
    input  logic [(1<<EXP_W)+MAN_W-1:0]  enc_val_i,
    output logic                         enc_vld_o,
    output logic [EXP_W+MAN_W-1:0]       enc_code_o
);
    localparam int CODE_W = EXP_W + MAN_W;
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam int MMAX   = (1 << MAN_W) - 1;
    localparam int VAL_W  = EMAX + 1 + MAN_W;
    localparam logic [VAL_W-1:0] SAT_LIM =
        VAL_W'((((1 << EMAX) - 1) << MAN_W) + (MMAX << EMAX));
    localparam logic [VAL_W-1:0] LIN_LIM = VAL_W'(1 << MAN_W);

    logic [VAL_W-1:0]  dec_val_d;
    logic [CODE_W-1:0] enc_code_d;

    log8_decoder #(.EXP_W(EXP_W), .MAN_W(MAN_W), .VAL_W(VAL_W)) u_dec (
        .code_i (dec_code_i),
        .val_o  (dec_val_d)
    );

    log8_encoder #(.EXP_W(EXP_W), .MAN_W(MAN_W), .VAL_W(VAL_W)) u_enc (
        .val_i  (enc_val_i),
        .code_o (enc_code_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld_o <= 1'b0;
            dec_val_o <= '0;
        end else begin
            dec_vld_o <= dec_vld_i;
            if (dec_vld_i) dec_val_o <= dec_val_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_vld_o  <= 1'b0;
            enc_code_o <= '0;
        end else begin
            enc_vld_o <= enc_vld_i;
            if (enc_vld_i) enc_code_o <= enc_code_d;
        end
    end

    // R2
    dec_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld_i |=> dec_vld_o);

    // R3
    enc_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_vld_i |=> enc_vld_o);

    // R9
    dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld_i |=> (!dec_vld_o && $stable(dec_val_o)));

    // R9
    enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_vld_i |=> (!enc_vld_o && $stable(enc_code_o)));

    // R6
    enc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_vld_i && enc_val_i >= SAT_LIM) |=> (enc_code_o == '1));

    // R5
    enc_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_vld_i && enc_val_i < LIN_LIM) |=>
            (enc_code_o == $past(enc_val_i[CODE_W-1:0])));
endmodule

// File: tb/log8_codec_bench.sv
module log8_codec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_vld_i = 1'b0;
    logic [7:0]  dec_code_i = '0;
    logic        dec_vld_o;
    logic [19:0] dec_val_o;
    logic        enc_vld_i = 1'b0;
    logic [19:0] enc_val_i = '0;
    logic        enc_vld_o;
    logic [7:0]  enc_code_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    log8_codec u_log8_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_vld_i  (dec_vld_i),
        .dec_code_i (dec_code_i),
        .dec_vld_o  (dec_vld_o),
        .dec_val_o  (dec_val_o),
        .enc_vld_i  (enc_vld_i),
        .enc_val_i  (enc_val_i),
        .enc_vld_o  (enc_vld_o),
        .enc_code_o (enc_code_o)
    );

    function automatic int ref_dec(input int c);
        int e = (c >> 4) & 15;
        int m = c & 15;
        return 16 * ((1 << e) - 1) + (m << e);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one decode; results are read on the following falling edge
    task automatic do_dec(input int c, output int v);
        @(negedge clk);
        dec_vld_i  = 1'b1;
        dec_code_i = c[7:0];
        @(negedge clk);
        dec_vld_i = 1'b0;
        v = int'(dec_val_o);
    endtask

    task automatic do_enc(input int v, output int c);
        @(negedge clk);
        enc_vld_i = 1'b1;
        enc_val_i = v[19:0];
        @(negedge clk);
        enc_vld_i = 1'b0;
        c = int'(enc_code_o);
    endtask

    task automatic t_reset();
        // R1
        chk("R1 dec_vld", int'(dec_vld_o), 0);
        chk("R1 dec_val", int'(dec_val_o), 0);
        chk("R1 enc_vld", int'(enc_vld_o), 0);
        chk("R1 enc_code", int'(enc_code_o), 0);
    endtask

    task automatic t_dec_directed();
        int codes [8] = '{8'h00, 8'h0F, 8'h10, 8'h30, 8'h40, 8'h41, 8'hF0, 8'hFF};
        int exps  [8] = '{0, 15, 16, 112, 240, 256, 524272, 1015792};
        int v;
        foreach (codes[i]) begin
            do_dec(codes[i], v);
            chk("R2 decode value", v, exps[i]);
            chk("R2 decode valid", int'(dec_vld_o), 1);
        end
    endtask

    task automatic t_enc_boundary();
        int vals [6] = '{240, 241, 239, 112, 111, 256};
        int exps [6] = '{8'h40, 8'h40, 8'h3F, 8'h30, 8'h2F, 8'h41};
        int c;
        foreach (vals[i]) begin
            do_enc(vals[i], c);
            chk("R4 boundary code", c, exps[i]);
            chk("R3 encode valid", int'(enc_vld_o), 1);
        end
    endtask

    task automatic t_enc_zero();
        int vals [4] = '{0, 5, 15, 16};
        int exps [4] = '{8'h00, 8'h05, 8'h0F, 8'h10};
        int c;
        foreach (vals[i]) begin
            do_enc(vals[i], c);
            chk("R5 low value code", c, exps[i]);
        end
    endtask

    task automatic t_enc_sat();
        int vals [4] = '{1015792, 1015793, 20'hFFFFF, 1015791};
        int exps [4] = '{8'hFF, 8'hFF, 8'hFF, 8'hFE};
        int c;
        foreach (vals[i]) begin
            do_enc(vals[i], c);
            chk("R6 saturation code", c, exps[i]);
        end
    endtask

    task automatic t_enc_trunc();
        int vals [4] = '{119, 120, 255, 127};
        int exps [4] = '{8'h30, 8'h31, 8'h40, 8'h31};
        int c;
        foreach (vals[i]) begin
            do_enc(vals[i], c);
            chk("R10 truncation code", c, exps[i]);
        end
    endtask

    task automatic t_roundtrip();
        int prev = -1;
        int v;
        int c;
        for (int k = 0; k < 256; k++) begin
            do_dec(k, v);
            chk("R2 decode sweep", v, ref_dec(k));
            chk("R8 strictly increasing", int'(v > prev), 1);
            prev = v;
            do_enc(v, c);
            chk("R7 round trip", c, k);
        end
    endtask

    task automatic t_hold();
        int v0;
        int c0;
        // Both paths in the same cycle
        @(negedge clk);
        dec_vld_i  = 1'b1;
        dec_code_i = 8'h52;
        enc_vld_i  = 1'b1;
        enc_val_i  = 20'd241;
        @(negedge clk);
        chk("R9 joint decode", int'(dec_val_o), ref_dec(8'h52));
        chk("R9 joint encode", int'(enc_code_o), 8'h40);
        v0 = int'(dec_val_o);
        c0 = int'(enc_code_o);
        // Valid low with changed data: outputs must not move
        dec_vld_i  = 1'b0;
        dec_code_i = 8'hFF;
        enc_vld_i  = 1'b0;
        enc_val_i  = 20'd5;
        @(negedge clk);
        chk("R9 dec valid drops", int'(dec_vld_o), 0);
        chk("R9 enc valid drops", int'(enc_vld_o), 0);
        @(negedge clk);
        chk("R9 dec value held", int'(dec_val_o), v0);
        chk("R9 enc code held", int'(enc_code_o), c0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dec_directed();
        t_enc_boundary();
        t_enc_zero();
        t_enc_sat();
        t_enc_trunc();
        t_roundtrip();
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule